// File: doc/BRIEF.md
# Virtual Channel Allocator

This block hands out downstream virtual channels to packets in a router with `P` ports and `V` virtual channels per port. Every input virtual channel (there are `P*V` of them) presents a head-ready flag, the output port chosen by route computation, a traffic class and a mask of output channels it would accept. The allocator matches these requesters against the `P*V` output channels. The match is a single cycle in two arbitration rounds: each requester first picks one candidate, then each output channel picks one of the requesters that chose it.

A granted output channel stays owned by its packet from the head flit to the tail flit. The block records the assigned port and channel for each input channel. Body and tail flits then follow that record without asking again. When the tail leaves, the input reports it and both the record and the output channel's busy bit are cleared. Busy output channels are removed from every request before arbitration, and an input channel that already holds an assignment does not request.

The input flags are stored into registers, so a grant and the matching busy bit appear at the clock edge that follows the request cycle. A released channel can be granted again one cycle after its release edge.

Top module: `vc_alloc`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `asg_vld`, `new_gnt` and `ovc_busy` are all zero.
- R2: An unassigned input channel i with `head_rdy[i]` high and at least one acceptable free output channel on its requested port may be granted. The grant is visible after the next clock edge: `asg_vld[i]`=1, `asg_port` slice i (bits i*PW and up) equals the requested port, and `new_gnt[i]` pulses high for exactly one cycle.
- R3: The granted channel index c lies in the class range of the request and has its bit set in the mask. Class k covers channel indices k*V/NCLS up to (k+1)*V/NCLS-1. A request whose mask has no bit inside its class range is never granted.
- R4: An output channel whose `ovc_busy` bit is set is never granted. Output channel (port p, channel c) has busy bit p*V+c, and that bit rises at the same edge as the grant. A requester whose first choice is busy picks a free one instead.
- R5: No output channel is owned by two input channels at once. At most one input channel wins each output channel per cycle, and `ovc_busy[o]` is set exactly when some valid assignment names channel o.
- R6: While assigned and without a tail report, an input channel keeps `asg_vld`, `asg_port` and `asg_vc` unchanged, whatever `head_rdy`, `head_port`, `head_cls` and `head_vmask` do.
- R7: `tail_sent[i]` with `asg_vld[i]`=1 clears `asg_vld[i]` and the owned busy bit at the next edge. The freed channel is not granted at that same edge. `tail_sent[i]` on an unassigned input has no effect.
- R8: Each output channel chooses among its requesters by round robin. After reset it favours the lowest index, and afterwards it favours the index just above its last winner.
- R9: Each input channel chooses among its free acceptable channels by round robin. After reset it favours the lowest channel index, and afterwards it favours the index just above its last granted channel.
- R10: A request with no free acceptable channel waits without effect and is granted in the cycle after a suitable channel is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_rdy | input | P*V | Head flit waiting, one bit per input channel |
| head_port | input | P*V*PW | Requested output port per input channel |
| head_cls | input | P*V*CW | Traffic class per input channel |
| head_vmask | input | P*V*V | Acceptable output channel indices per input channel |
| tail_sent | input | P*V | Tail flit of the owning packet has left |
| asg_vld | output | P*V | Input channel holds an assignment |
| asg_port | output | P*V*PW | Assigned output port |
| asg_vc | output | P*V*VW | Assigned output channel index |
| new_gnt | output | P*V | One-cycle pulse marking a fresh assignment |
| ovc_busy | output | P*V | Ownership state of each output channel, bit p*V+c |

## Verification
The assertions assume that `head_port` stays below `P`, that `V` divides evenly into `NCLS` classes, and that a tail report stands for the packet whose head was granted. They also assume that a freshly granted channel's previous-cycle request fields are the ones that produced the grant. The stimulus uses the default four ports and two classes. It raises `tail_sent` only for one cycle per packet, except for one deliberate extra pulse on an idle input. It changes request fields only on inputs that are idle, or that already hold an assignment so that the change must be ignored. Contention cases are set up so that each round-robin pointer position can be known from the earlier scenarios.

// File: rtl/vca_pkg.sv
package vca_pkg;
  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req,
  input  logic         adv,
  output logic [W-1:0] gnt
);
  localparam int IW = vca_pkg::bits_for(W);

  logic [IW-1:0] ptr;
  int            win;
  int            idx;
  logic          found;

  // first requester at or above the pointer, wrapping around
  always_comb begin
    gnt   = '0;
    win   = 0;
    idx   = 0;
    found = 1'b0;
    for (int k = 0; k < W; k++) begin
      idx = (int'(ptr) + k) % W;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        win      = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv && found) begin
      ptr <= (win == W - 1) ? '0 : IW'(win + 1);
    end
  end
endmodule

// File: rtl/vca_in_stage.sv
module vca_in_stage #(
  parameter int P    = 4,
  parameter int V    = 4,
  parameter int NCLS = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req,
  input  logic [vca_pkg::bits_for(P)-1:0]   port,
  input  logic [vca_pkg::bits_for(NCLS)-1:0] cls,
  input  logic [V-1:0]                      vmask,
  input  logic [P*V-1:0]                    busy,
  input  logic                              adv,
  output logic [P*V-1:0]                    pick
);
  localparam int VPC = V / NCLS;

  logic [V-1:0] free_v;
  logic [V-1:0] cls_ok;
  logic [V-1:0] cand;
  logic [V-1:0] vpick;

  always_comb begin
    free_v = '0;
    for (int p = 0; p < P; p++) begin
      if (int'(port) == p) free_v = ~busy[p*V +: V];
    end
    for (int v = 0; v < V; v++) begin
      cls_ok[v] = ((v / VPC) == int'(cls));
    end
    cand = req ? (vmask & cls_ok & free_v) : '0;
  end

  vca_rr_arb #(.W(V)) u_pick (
    .clk (clk),
    .rst (rst),
    .req (cand),
    .adv (adv),
    .gnt (vpick)
  );

  always_comb begin
    pick = '0;
    for (int p = 0; p < P; p++) begin
      if (int'(port) == p) pick[p*V +: V] = vpick;
    end
  end
endmodule

// File: rtl/vca_ledger.sv
module vca_ledger #(
  parameter int P = 4,
  parameter int V = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [P*V-1:0]       won,
  input  logic [P*V*vca_pkg::bits_for(P)-1:0] w_port,
  input  logic [P*V*vca_pkg::bits_for(V)-1:0] w_vc,
  input  logic [P*V-1:0]       tail_sent,
  output logic [P*V-1:0]       asg_vld,
  output logic [P*V*vca_pkg::bits_for(P)-1:0] asg_port,
  output logic [P*V*vca_pkg::bits_for(V)-1:0] asg_vc,
  output logic [P*V-1:0]       new_gnt,
  output logic [P*V-1:0]       ovc_busy
);
  localparam int N  = P * V;
  localparam int M  = P * V;
  localparam int PW = vca_pkg::bits_for(P);
  localparam int VW = vca_pkg::bits_for(V);

  logic [M-1:0] set_m;
  logic [M-1:0] clr_m;
  int           oi;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    oi    = 0;
    for (int i = 0; i < N; i++) begin
      if (asg_vld[i] && tail_sent[i]) begin
        oi = int'(asg_port[i*PW +: PW]) * V + int'(asg_vc[i*VW +: VW]);
        if (oi < M) clr_m[oi] = 1'b1;
      end
      if (won[i]) begin
        oi = int'(w_port[i*PW +: PW]) * V + int'(w_vc[i*VW +: VW]);
        if (oi < M) set_m[oi] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asg_vld  <= '0;
      asg_port <= '0;
      asg_vc   <= '0;
      new_gnt  <= '0;
      ovc_busy <= '0;
    end else begin
      ovc_busy <= (ovc_busy & ~clr_m) | set_m;
      new_gnt  <= won;
      for (int i = 0; i < N; i++) begin
        if (asg_vld[i] && tail_sent[i]) begin
          asg_vld[i] <= 1'b0;
        end else if (won[i]) begin
          asg_vld[i]             <= 1'b1;
          asg_port[i*PW +: PW]   <= w_port[i*PW +: PW];
          asg_vc[i*VW +: VW]     <= w_vc[i*VW +: VW];
        end
      end
    end
  end
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
  parameter int P    = 4,
  parameter int V    = 4,
  parameter int NCLS = 2
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [P*V-1:0]                          head_rdy,
  input  logic [P*V*vca_pkg::bits_for(P)-1:0]     head_port,
  input  logic [P*V*vca_pkg::bits_for(NCLS)-1:0]  head_cls,
  input  logic [P*V*V-1:0]                        head_vmask,
  input  logic [P*V-1:0]                          tail_sent,
  output logic [P*V-1:0]                          asg_vld,
  output logic [P*V*vca_pkg::bits_for(P)-1:0]     asg_port,
  output logic [P*V*vca_pkg::bits_for(V)-1:0]     asg_vc,
  output logic [P*V-1:0]                          new_gnt,
  output logic [P*V-1:0]                          ovc_busy
);
  localparam int N  = P * V;
  localparam int M  = P * V;
  localparam int PW = vca_pkg::bits_for(P);
  localparam int VW = vca_pkg::bits_for(V);
  localparam int CW = vca_pkg::bits_for(NCLS);

  logic [N-1:0]    req_eff;
  logic [M-1:0]    pick [N];
  logic [N-1:0]    col  [M];
  logic [N-1:0]    ogn  [M];
  logic [N-1:0]    won;
  logic [N*PW-1:0] w_port;
  logic [N*VW-1:0] w_vc;

  // only input channels without an assignment compete
  assign req_eff = head_rdy & ~asg_vld;

  for (genvar i = 0; i < N; i++) begin : g_in
    vca_in_stage #(.P(P), .V(V), .NCLS(NCLS)) u_in (
      .clk   (clk),
      .rst   (rst),
      .req   (req_eff[i]),
      .port  (head_port[i*PW +: PW]),
      .cls   (head_cls[i*CW +: CW]),
      .vmask (head_vmask[i*V +: V]),
      .busy  (ovc_busy),
      .adv   (won[i]),
      .pick  (pick[i])
    );
  end

  always_comb begin
    for (int o = 0; o < M; o++) begin
      for (int i = 0; i < N; i++) begin
        col[o][i] = pick[i][o];
      end
    end
  end

  for (genvar o = 0; o < M; o++) begin : g_out
    vca_rr_arb #(.W(N)) u_out (
      .clk (clk),
      .rst (rst),
      .req (col[o]),
      .adv (1'b1),
      .gnt (ogn[o])
    );
  end

  always_comb begin
    won    = '0;
    w_port = '0;
    w_vc   = '0;
    for (int o = 0; o < M; o++) begin
      for (int i = 0; i < N; i++) begin
        if (ogn[o][i]) begin
          won[i]             = 1'b1;
          w_port[i*PW +: PW] = PW'(o / V);
          w_vc[i*VW +: VW]   = VW'(o % V);
        end
      end
    end
  end

  vca_ledger #(.P(P), .V(V)) u_ledger (
    .clk       (clk),
    .rst       (rst),
    .won       (won),
    .w_port    (w_port),
    .w_vc      (w_vc),
    .tail_sent (tail_sent),
    .asg_vld   (asg_vld),
    .asg_port  (asg_port),
    .asg_vc    (asg_vc),
    .new_gnt   (new_gnt),
    .ovc_busy  (ovc_busy)
  );
endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
  parameter int P    = 4,
  parameter int V    = 4,
  parameter int NCLS = 2
) (
  input logic                                    clk,
  input logic                                    rst,
  input logic [P*V-1:0]                          head_rdy,
  input logic [P*V*vca_pkg::bits_for(P)-1:0]     head_port,
  input logic [P*V*vca_pkg::bits_for(NCLS)-1:0]  head_cls,
  input logic [P*V*V-1:0]                        head_vmask,
  input logic [P*V-1:0]                          tail_sent,
  input logic [P*V-1:0]                          asg_vld,
  input logic [P*V*vca_pkg::bits_for(P)-1:0]     asg_port,
  input logic [P*V*vca_pkg::bits_for(V)-1:0]     asg_vc,
  input logic [P*V-1:0]                          new_gnt,
  input logic [P*V-1:0]                          ovc_busy
);
  localparam int N   = P * V;
  localparam int M   = P * V;
  localparam int PW  = vca_pkg::bits_for(P);
  localparam int VW  = vca_pkg::bits_for(V);
  localparam int CW  = vca_pkg::bits_for(NCLS);
  localparam int VPC = V / NCLS;

  logic [N-1:0]    p_rdy;
  logic [N*PW-1:0] p_port;
  logic [N*CW-1:0] p_cls;
  logic [N*V-1:0]  p_vmask;
  logic [M-1:0]    p_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_rdy <= '0; p_port <= '0; p_cls <= '0; p_vmask <= '0; p_busy <= '0;
    end else begin
      p_rdy <= head_rdy; p_port <= head_port; p_cls <= head_cls;
      p_vmask <= head_vmask; p_busy <= ovc_busy;
    end
  end

  logic [M-1:0] own  [N];
  logic [N-1:0] ocol [M];
  logic [N-1:0] ok_port, ok_cls, ok_mask, ok_free;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      own[i] = '0;
      if (asg_vld[i])
        own[i][int'(asg_port[i*PW +: PW]) * V + int'(asg_vc[i*VW +: VW])] = 1'b1;
      ok_port[i] = (asg_port[i*PW +: PW] == p_port[i*PW +: PW]);
      ok_cls[i]  = ((int'(asg_vc[i*VW +: VW]) / VPC) == int'(p_cls[i*CW +: CW]));
      ok_mask[i] = p_vmask[i*V + int'(asg_vc[i*VW +: VW])];
      ok_free[i] = ((p_busy & own[i]) == '0);
    end
    for (int o = 0; o < M; o++)
      for (int i = 0; i < N; i++)
        ocol[o][i] = own[i][o];
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (asg_vld == '0 && new_gnt == '0 && ovc_busy == '0)); // R1

  for (genvar i = 0; i < N; i++) begin : g_chk_in
    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst) $rose(asg_vld[i]) |-> (p_rdy[i] && new_gnt[i] && ok_port[i])); // R2
    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst) new_gnt[i] |-> $rose(asg_vld[i])); // R2
    AST_GRANT_IN_CLASS: assert property (@(posedge clk) disable iff (rst) $rose(asg_vld[i]) |-> (ok_cls[i] && ok_mask[i])); // R3
    AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (rst) $rose(asg_vld[i]) |-> ok_free[i]); // R4
    AST_ASSIGN_HELD: assert property (@(posedge clk) disable iff (rst) (asg_vld[i] && !tail_sent[i]) |=> (asg_vld[i] && $stable(asg_port[i*PW +: PW]) && $stable(asg_vc[i*VW +: VW]))); // R6
    AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (rst) (asg_vld[i] && tail_sent[i]) |=> !asg_vld[i]); // R7
  end

  for (genvar o = 0; o < M; o++) begin : g_chk_out
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst) $countones(ocol[o]) <= 1); // R5
    AST_BUSY_MATCHES_OWNER: assert property (@(posedge clk) disable iff (rst) ovc_busy[o] == (|ocol[o])); // R5
  end
endmodule

bind vc_alloc vca_checker #(.P(P), .V(V), .NCLS(NCLS)) i_vca_checker (
  .clk        (clk),
  .rst        (rst),
  .head_rdy   (head_rdy),
  .head_port  (head_port),
  .head_cls   (head_cls),
  .head_vmask (head_vmask),
  .tail_sent  (tail_sent),
  .asg_vld    (asg_vld),
  .asg_port   (asg_port),
  .asg_vc     (asg_vc),
  .new_gnt    (new_gnt),
  .ovc_busy   (ovc_busy)
);

// File: tb/test_vc_alloc.sv
`timescale 1ns/1ps
module test_vc_alloc;
  localparam int P = 4, V = 4, NCLS = 2;
  localparam int N = P * V, M = P * V;
  localparam int PW = 2, VW = 2, CW = 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    head_rdy;
  logic [N*PW-1:0] head_port;
  logic [N*CW-1:0] head_cls;
  logic [N*V-1:0]  head_vmask;
  logic [N-1:0]    tail_sent;
  logic [N-1:0]    asg_vld;
  logic [N*PW-1:0] asg_port;
  logic [N*VW-1:0] asg_vc;
  logic [N-1:0]    new_gnt;
  logic [M-1:0]    ovc_busy;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  vc_alloc #(.P(P), .V(V), .NCLS(NCLS)) i_vc_alloc (
    .clk(clk), .rst(rst), .head_rdy(head_rdy), .head_port(head_port),
    .head_cls(head_cls), .head_vmask(head_vmask), .tail_sent(tail_sent),
    .asg_vld(asg_vld), .asg_port(asg_port), .asg_vc(asg_vc),
    .new_gnt(new_gnt), .ovc_busy(ovc_busy)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int a_port(input int i);
    return int'(asg_port[i*PW +: PW]);
  endfunction

  function automatic int a_vc(input int i);
    return int'(asg_vc[i*VW +: VW]);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_req(input int i, input int port, input int cls, input logic [V-1:0] m);
    head_rdy[i]             = 1'b1;
    head_port[i*PW +: PW]   = PW'(port);
    head_cls[i*CW +: CW]    = CW'(cls);
    head_vmask[i*V +: V]    = m;
  endtask

  task automatic release_in(input int i);
    head_rdy[i]  = 1'b0;
    tail_sent[i] = 1'b1;
    tick();
    tail_sent[i] = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1", "asg_vld in reset", int'(asg_vld), 0);
    chk("R1", "ovc_busy in reset", int'(ovc_busy), 0);
    chk("R1", "new_gnt in reset", int'(new_gnt), 0);
    rst = 1'b0;
    tick();
    chk("R1", "ovc_busy after reset", int'(ovc_busy), 0);
  endtask

  task automatic t_basic();
    set_req(5, 2, 1, 4'b1111);
    tick();
    chk("R2", "asg_vld[5]", int'(asg_vld[5]), 1);
    chk("R2", "asg_port[5]", a_port(5), 2);
    chk("R3", "asg_vc[5] first in class 1", a_vc(5), 2);
    chk("R2", "new_gnt pulse", int'(new_gnt), 32);
    chk("R4", "busy bit 10", int'(ovc_busy), 16'h0400);
    tick();
    chk("R2", "new_gnt one cycle", int'(new_gnt), 0);
    head_port[5*PW +: PW] = 2'd0;
    head_vmask[5*V +: V]  = 4'b0001;
    tick();
    chk("R6", "port held", a_port(5), 2);
    chk("R6", "vc held", a_vc(5), 2);
    chk("R6", "still valid", int'(asg_vld[5]), 1);
    release_in(5);
    chk("R7", "released asg_vld", int'(asg_vld), 0);
    chk("R7", "released busy", int'(ovc_busy), 0);
    tail_sent[5] = 1'b1;
    tick();
    tail_sent[5] = 1'b0;
    chk("R7", "idle tail ignored asg_vld", int'(asg_vld), 0);
    chk("R7", "idle tail ignored busy", int'(ovc_busy), 0);
  endtask

  task automatic t_class_empty();
    set_req(2, 0, 1, 4'b0011);
    repeat (3) tick();
    chk("R3", "mask outside class never granted", int'(asg_vld[2]), 0);
    chk("R3", "no busy from empty request", int'(ovc_busy), 0);
    head_rdy[2] = 1'b0;
    tick();
  endtask

  task automatic t_busy_wait();
    set_req(3, 1, 0, 4'b0001);
    tick();
    chk("R2", "input 3 port", a_port(3), 1);
    chk("R4", "busy bit 4", int'(ovc_busy), 16'h0010);
    set_req(7, 1, 0, 4'b0001);
    repeat (2) tick();
    chk("R4", "busy vc not granted", int'(asg_vld[7]), 0);
    chk("R10", "waiting no pulse", int'(new_gnt), 0);
    release_in(3);
    chk("R7", "freed not reused same edge", int'(asg_vld[7]), 0);
    chk("R7", "busy cleared", int'(ovc_busy), 0);
    tick();
    chk("R10", "waiter granted", int'(asg_vld[7]), 1);
    chk("R10", "waiter vc", a_vc(7), 0);
    chk("R10", "busy bit 4 again", int'(ovc_busy), 16'h0010);
    release_in(7);
    chk("R7", "all free", int'(ovc_busy), 0);
  endtask

  task automatic t_rr_out();
    set_req(0, 0, 0, 4'b0001);
    set_req(1, 0, 0, 4'b0001);
    tick();
    chk("R8", "lowest index first", int'(asg_vld[1:0]), 1);
    tail_sent[0] = 1'b1;
    tick();
    tail_sent[0] = 1'b0;
    chk("R8", "both unassigned", int'(asg_vld[1:0]), 0);
    tick();
    chk("R8", "rotated winner", int'(asg_vld[1:0]), 2);
    head_rdy[0] = 1'b0;
    release_in(1);
    tick();
    chk("R8", "cleanup busy", int'(ovc_busy), 0);
  endtask

  task automatic t_rr_in();
    set_req(9, 3, 0, 4'b0011);
    tick();
    chk("R9", "first input pick", a_vc(9), 0);
    release_in(9);
    set_req(9, 3, 0, 4'b0011);
    tick();
    chk("R9", "rotated input pick", a_vc(9), 1);
    release_in(9);
    set_req(10, 3, 0, 4'b0001);
    tick();
    chk("R2", "input 10 vc", a_vc(10), 0);
    set_req(11, 3, 0, 4'b0011);
    tick();
    chk("R4", "skips busy candidate", a_vc(11), 1);
    chk("R4", "busy bits 12 13", int'(ovc_busy), 16'h3000);
    head_rdy[10] = 1'b0;
    head_rdy[11] = 1'b0;
    tail_sent[10] = 1'b1;
    tail_sent[11] = 1'b1;
    tick();
    tail_sent = '0;
    chk("R7", "both released", int'(ovc_busy), 0);
  endtask

  task automatic t_contend();
    for (int i = 12; i < 16; i++) set_req(i, 2, 1, 4'b1100);
    tick();
    chk("R5", "one winner", $countones(new_gnt), 1);
    chk("R8", "winner is 12", int'(new_gnt[15:12]), 1);
    chk("R5", "busy bit 10", int'(ovc_busy), 16'h0400);
    tick();
    chk("R5", "second winner 13", int'(new_gnt[15:12]), 2);
    chk("R9", "input 13 vc", a_vc(13), 3);
    tick();
    chk("R10", "rest wait", int'(asg_vld[15:12]), 3);
    chk("R5", "busy bits 10 11", int'(ovc_busy), 16'h0C00);
    head_rdy = '0;
    tail_sent[12] = 1'b1;
    tail_sent[13] = 1'b1;
    tick();
    tail_sent = '0;
    tick();
    chk("R7", "final asg", int'(asg_vld), 0);
    chk("R7", "final busy", int'(ovc_busy), 0);
  endtask

  initial begin
    head_rdy   = '0;
    head_port  = '0;
    head_cls   = '0;
    head_vmask = '0;
    tail_sent  = '0;
    t_reset();
    t_basic();
    t_class_empty();
    t_busy_wait();
    t_rr_out();
    t_rr_in();
    t_contend();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule